// File: doc/BRIEF.md
# Single-Channel Cycle-Stealing Block Transfer Engine

This block copies a block of data between one peripheral and memory while the processor keeps running between data. Software programs three values through a small register port: the memory address of the first datum, the number of bytes still to move, and a control word. The control word picks the direction and the datum size, and a start bit in it launches the block. Data moves straight between the peripheral and memory over the shared bus. The block itself only supplies the address, the peripheral acknowledge and the memory strobe, and it never holds the data.

For every peripheral request the block asks the processor for the bus by raising `hold`. It waits for `hlda` before it drives anything. It then drives the address together with the acknowledge and one memory strobe for a single cycle. It turns its bus outputs off, drops `hold`, steps the address and the remaining count, and waits for `hlda` to fall. The bus is returned after every datum. When the remaining count reaches zero the block goes idle and reports completion in its status word.

Top module: `blk_dma`

## Requirements
- R1: After reset the block is idle: `hold`, `bus_oe`, `dev_ack`, `mem_rd` and `mem_wr` are low, and the status word (select 3) reads 0. Address (select 0) and count (select 1) read 0.
- R2: While idle, a register write takes effect on the next clock and reads back. Select 0 is the address and select 1 is the byte count. Select 2 is control: bit 0 is direction (1 = memory to peripheral, 0 = peripheral to memory), bit 1 is word size, and bit 2 is start. Control reads back bits 1:0, and the start bit always reads 0.
- R3: Writing control with bit 2 set while idle and with a nonzero count makes status bit 0 (busy) read 1 and clears status bit 1 (done). If the count is zero, done reads 1 right away, busy stays 0, and no bus request is made.
- R4: On a peripheral request while busy, the block raises `hold` and drives no address, acknowledge or strobe until `hlda` is high.
- R5: Each datum is one granted cycle in which `bus_oe` and `dev_ack` are high and `bus_addr` shows the current address. In that cycle `mem_rd` is high for memory-to-peripheral transfers and `mem_wr` is high for peripheral-to-memory transfers, never both.
- R6: The bus outputs are off for at least one cycle before `hold` falls. After `hold` falls, the next datum is not started until `hlda` has gone low.
- R7: After each datum the address grows by 1 in byte mode and by 2 in word mode, and the count shrinks by the same amount.
- R8: When the count reaches zero the block becomes idle with done set. In word mode an odd count ends at zero and does not wrap.
- R9: Peripheral requests while idle, including after done, raise no `hold` and change no register.
- R10: Register writes while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 status |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Read data of the selected register |
| dev_req | input | 1 | Peripheral request, level |
| dev_ack | output | 1 | Peripheral acknowledge for the datum on the bus |
| hold | output | 1 | Bus request to the processor |
| hlda | input | 1 | Bus grant from the processor |
| bus_oe | output | 1 | Enable for the address and strobe drivers |
| bus_addr | output | W | Memory address of the datum |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
The hardest situation to reach from the ports is a register write that lands while a block is in flight. The write must arrive after start and before the block ends, but the block ends on its own as soon as requests are served. The stimulus therefore starts a block with the peripheral model held quiet, so the engine parks waiting for a request. It then writes new address and count values, reads both back unchanged, and only then lets the peripheral issue its requests. Grant latency in the bench's arbiter model is also varied so that `hold` stays raised for several cycles without `hlda`, which exposes any early driving of the bus.

// File: rtl/blk_dma.sv
module blk_dma #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         dev_req,
  output logic         dev_ack,
  output logic         hold,
  input  logic         hlda,
  output logic         bus_oe,
  output logic [W-1:0] bus_addr,
  output logic         mem_rd,
  output logic         mem_wr
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_REQ, S_XFER, S_REL, S_DROP} st_t;

  st_t         st;
  logic [W-1:0] addr_q, cnt_q;
  logic         dir_q, word_q, done_q;

  wire          busy    = (st != S_IDLE);
  wire          host_wr = reg_wr && !busy;
  wire          start   = host_wr && (reg_sel == 2'd2) && reg_wdata[2];
  wire [W-1:0]  step    = word_q ? W'(2) : W'(1);
  wire          last    = (cnt_q <= step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      word_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (host_wr) begin
        case (reg_sel)
          2'd0: addr_q <= reg_wdata;
          2'd1: cnt_q  <= reg_wdata;
          2'd2: begin
            dir_q  <= reg_wdata[0];
            word_q <= reg_wdata[1];
          end
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (start) begin
          done_q <= (cnt_q == '0);
          if (cnt_q != '0) st <= S_WAIT;
        end
        S_WAIT: if (dev_req) st <= S_REQ;
        S_REQ:  if (hlda) st <= S_XFER;
        S_XFER: st <= S_REL;
        S_REL: begin
          addr_q <= addr_q + step;
          cnt_q  <= last ? '0 : cnt_q - step;
          st     <= S_DROP;
        end
        S_DROP: if (!hlda) begin
          if (cnt_q == '0) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= S_WAIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign hold     = (st == S_REQ) || (st == S_XFER) || (st == S_REL);
  assign bus_oe   = (st == S_XFER);
  assign dev_ack  = bus_oe;
  assign mem_rd   = bus_oe && dir_q;
  assign mem_wr   = bus_oe && !dir_q;
  assign bus_addr = bus_oe ? addr_q : '0;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = addr_q;
      2'd1:    reg_rdata = cnt_q;
      2'd2:    reg_rdata = W'({word_q, dir_q});
      default: reg_rdata = W'({done_q, busy});
    endcase
  end

  p_grant_before_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (hlda && hold));

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}) && (dev_ack == bus_oe));

  p_quiet_before_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> (!bus_oe && $past(!bus_oe)));

  p_start_clears_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done_q);

  p_count_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REL) |=> (cnt_q <= $past(cnt_q)));

  p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_sel == 2'd1 && st != S_REL) |=> $stable(cnt_q));

  p_idle_no_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !hold);

endmodule

// File: tb/blk_dma_tb.sv
module blk_dma_tb;
  localparam int W = 16;

  logic         clk = 0, rst_n = 0;
  logic         reg_wr = 0;
  logic [1:0]   reg_sel = 0;
  logic [W-1:0] reg_wdata = 0, reg_rdata;
  logic         dev_req, dev_ack, hold, hlda, bus_oe, mem_rd, mem_wr;
  logic [W-1:0] bus_addr;
  logic         req_manual = 0;

  always #4 clk = ~clk;

  blk_dma #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
    .dev_ack(dev_ack), .hold(hold), .hlda(hlda), .bus_oe(bus_oe),
    .bus_addr(bus_addr), .mem_rd(mem_rd), .mem_wr(mem_wr));

  int lat = 1, gcnt = 0;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin hlda <= 0; gcnt <= 0; end
    else if (!hold) begin hlda <= 0; gcnt <= 0; end
    else if (gcnt >= lat) hlda <= 1;
    else gcnt <= gcnt + 1;

  int req_target = 0, req_issued = 0;
  logic dev_req_q;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin dev_req_q <= 0; req_issued <= 0; end
    else if (dev_ack) begin dev_req_q <= 0; req_issued <= req_issued + 1; end
    else if (req_issued < req_target) dev_req_q <= 1;
  assign dev_req = dev_req_q || req_manual;

  logic [W:0] expq[$];
  int checks = 0, fails = 0, mchecks = 0, mfails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp); end
  endtask

  task automatic mchk(input bit ok, input string tag, input int act, input int exp);
    mchecks++;
    if (!ok) begin mfails++; $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp); end
  endtask

  logic prev_hold = 0, prev_oe = 0, wait_low = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_oe) begin
        logic [W:0] e;
        mchk(hlda === 1'b1, "R4 drive only with grant", hlda, 1);
        mchk(!wait_low, "R6 datum before hlda low", wait_low, 0);
        if (expq.size() == 0) mchk(0, "R5 unexpected datum", bus_addr, 0);
        else begin
          e = expq.pop_front();
          mchk(bus_addr == e[W-1:0], "R5/R7 address", bus_addr, e[W-1:0]);
          mchk({mem_rd, mem_wr, dev_ack} == {e[W], !e[W], 1'b1}, "R5 strobes",
               {mem_rd, mem_wr, dev_ack}, {e[W], !e[W], 1'b1});
        end
      end
      if (prev_hold && !hold) begin
        mchk(!prev_oe && !bus_oe, "R6 outputs off before hold drop", prev_oe, 0);
        wait_low = 1;
      end
      if (!hlda) wait_low = 0;
      prev_hold = hold; prev_oe = bus_oe;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [W-1:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic push(input bit rdir, input logic [W-1:0] a0, input int n, input int stp);
    for (int i = 0; i < n; i++) expq.push_back({rdir, a0 + W'(i * stp)});
  endtask

  task automatic wait_idle(input string tag);
    logic [W-1:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); rd(2'd3, s);
      if (s[0] == 0) return;
    end
    chk(0, tag, 1, 0);
  endtask

  initial begin
    #(8 * 200000);
    $display("FAIL watchdog expired actual=0x1 expected=0x0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + mchecks + 1, fails + mfails + 1);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({hold, bus_oe, dev_ack, mem_rd, mem_wr} == 0, "R1 bus outputs", {hold, bus_oe, dev_ack, mem_rd, mem_wr}, 0);
    rd(2'd3, v); chk(v == 0, "R1 status", v, 0);
    rd(2'd0, v); chk(v == 0, "R1 address", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 count", v, 0);

    wr(2'd0, 16'h1000); wr(2'd1, 16'd4); wr(2'd2, 16'h0003);
    rd(2'd0, v); chk(v == 16'h1000, "R2 address readback", v, 16'h1000);
    rd(2'd1, v); chk(v == 4, "R2 count readback", v, 4);
    rd(2'd2, v); chk(v == 3, "R2 control readback", v, 3);
    wr(2'd2, 16'h0000);
    rd(2'd2, v); chk(v == 0, "R2 control rewrite", v, 0);

    req_manual = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); chk(!hold, "R9 idle request ignored", hold, 0);
    end
    req_manual = 0;
    rd(2'd0, v); chk(v == 16'h1000, "R9 address untouched", v, 16'h1000);

    push(0, 16'h1000, 4, 1);
    wr(2'd2, 16'h0004);
    rd(2'd3, v); chk(v == 1, "R3 busy after start", v, 1);
    lat = 4;
    req_target += 4;
    wait_idle("R8 byte block end");
    rd(2'd3, v); chk(v == 2, "R8 done set", v, 2);
    rd(2'd0, v); chk(v == 16'h1004, "R7 byte address step", v, 16'h1004);
    rd(2'd1, v); chk(v == 0, "R8 count zero", v, 0);

    lat = 1;
    wr(2'd0, 16'h2000); wr(2'd1, 16'd6);
    push(1, 16'h2000, 3, 2);
    wr(2'd2, 16'h0007);
    rd(2'd3, v); chk(v == 1, "R3 done cleared on start", v, 1);
    req_target += 3;
    wait_idle("R8 word block end");
    rd(2'd0, v); chk(v == 16'h2006, "R7 word address step", v, 16'h2006);
    rd(2'd1, v); chk(v == 0, "R7 word count step", v, 0);

    lat = 2;
    wr(2'd0, 16'h3000); wr(2'd1, 16'd3);
    push(0, 16'h3000, 2, 2);
    wr(2'd2, 16'h0006);
    req_target += 2;
    wait_idle("R8 odd word end");
    rd(2'd1, v); chk(v == 0, "R8 odd count no wrap", v, 0);
    rd(2'd0, v); chk(v == 16'h3004, "R8 odd address", v, 16'h3004);
    rd(2'd3, v); chk(v == 2, "R8 odd done", v, 2);

    wr(2'd0, 16'h4000); wr(2'd1, 16'd2);
    wr(2'd2, 16'h0004);
    wr(2'd0, 16'hFFFF); wr(2'd1, 16'd9); wr(2'd2, 16'h0003);
    rd(2'd0, v); chk(v == 16'h4000, "R10 address write ignored", v, 16'h4000);
    rd(2'd1, v); chk(v == 2, "R10 count write ignored", v, 2);
    rd(2'd2, v); chk(v == 0, "R10 control write ignored", v, 0);
    push(0, 16'h4000, 2, 1);
    req_target += 2;
    wait_idle("R10 block end");
    rd(2'd0, v); chk(v == 16'h4002, "R10 block ran from original", v, 16'h4002);

    req_manual = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); chk(!hold, "R9 request after done ignored", hold, 0);
    end
    req_manual = 0;
    rd(2'd0, v); chk(v == 16'h4002, "R9 address after done", v, 16'h4002);
    rd(2'd3, v); chk(v == 2, "R9 status after done", v, 2);

    wr(2'd1, 16'd0);
    wr(2'd2, 16'h0004);
    rd(2'd3, v); chk(v == 2, "R3 zero count done at once", v, 2);
    repeat (4) @(negedge clk);
    chk(!hold, "R3 zero count no request", hold, 0);

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R5 all data seen", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + mchecks, fails + mfails);
    $finish;
  end
endmodule